// File: doc/BRIEF.md
# Undocumented Opcode Execute Unit

This block is the execute step for a handful of undocumented 8-bit processor opcodes that fuse an AND with a rotate, a subtract or a store. A strobe presents the opcode, the accumulator, X, the incoming carry, the fetched operand, the high byte of the effective address and a page-crossing flag. One clock later the block returns new A, X and S values, a store data byte, an optional replacement for the store address high byte, and new N, V, Z and C values. Each result carries its own enable.

The surrounding core owns operand fetch, address generation and bus timing. It applies each result only where the matching enable is set. Flags whose enable is clear keep their old values in the core, so the block only needs the incoming carry among the flags. The implementation-dependent constant that two of the opcodes OR into A is the parameter `MAGIC_K`, with default 0xEE.

Top module: `undoc_exec_unit`

## Requirements
- R1: A synchronous active-high reset drives every data output, every write enable, every flag output and the flag-enable mask to zero.
- R2: Opcode 0x6B computes t = A AND operand, then rotates t right with the incoming carry entering bit 7. The result goes to A with the A enable set. N = result bit 7, Z = (result == 0), C = result bit 6 and V = result bit 6 XOR result bit 5. The flag mask is 4'b1111, laid out as {N,V,Z,C}.
- R3: Opcode 0xCB writes ((A AND X) − operand) mod 256 to X with the X enable set. C = 1 when (A AND X) ≥ operand, and N and Z follow the result. The mask is 4'b1011, so V is not updated.
- R4: Opcode 0xAB writes (A OR MAGIC_K) AND operand to both A and X, with both enables set. N and Z follow the result, and the mask is 4'b1010.
- R5: Opcode 0x8B writes (A OR MAGIC_K) AND X AND operand to A. N and Z follow the result, and the mask is 4'b1010.
- R6: Opcodes 0x9F and 0x93 store A AND X AND (address high + 1) with the store enable set. No register enable and no flag enable is set.
- R7: Opcode 0x9B writes A AND X to S with the S enable set. It stores (A AND X) AND (address high + 1), and sets no flag enable.
- R8: The address high + 1 term wraps modulo 256, so a high byte of 0xFF gives a term of 0x00 and a stored byte of 0x00.
- R9: For the three store opcodes with page-crossing asserted, the address-high override output equals the stored byte and its enable is set. Without page-crossing, the override and its enable are zero.
- R10: A strobe carrying any other opcode makes every enable and every data output zero.
- R11: Results appear exactly one clock after the strobe. All outputs hold while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe that launches one operation |
| in_opcode | input | 8 | Opcode byte |
| in_a | input | 8 | Accumulator |
| in_x | input | 8 | X index register |
| in_c | input | 1 | Incoming carry flag |
| in_oper | input | 8 | Operand byte |
| in_addr_hi | input | 8 | High byte of the effective address |
| in_page_cross | input | 1 | Address computation crossed a page |
| out_a | output | 8 | New accumulator value |
| out_a_we | output | 1 | Accumulator write enable |
| out_x | output | 8 | New X value |
| out_x_we | output | 1 | X write enable |
| out_s | output | 8 | New stack pointer value |
| out_s_we | output | 1 | Stack pointer write enable |
| out_mem_data | output | 8 | Store data byte |
| out_mem_we | output | 1 | Store enable |
| out_addr_hi | output | 8 | Replacement store address high byte |
| out_addr_hi_we | output | 1 | Address high override enable |
| out_n | output | 1 | New N flag |
| out_v | output | 1 | New V flag |
| out_z | output | 1 | New Z flag |
| out_c | output | 1 | New C flag |
| out_flag_we | output | 4 | Flag update mask {N,V,Z,C} |

## Verification
Every result of a strobe is due on the first rising edge after the cycle in which the strobe was driven. All outputs stay unchanged through any following cycles without a strobe. The bench keeps a behavioural model that updates on the same edge as the design. It compares the whole output bundle at the falling edge of every clock, and drives new inputs only after that comparison, so each comparison sees the result of exactly one register stage. The directed vectors cover a high byte of 0xFF, the borrow edge where (A AND X) equals the operand, carry in and out of the rotate, and unknown opcodes. Random strobes separated by idle gaps cover the hold behaviour.

// File: rtl/undoc_pkg.sv
package undoc_pkg;
  localparam int UX_W = 8;

  localparam logic [7:0] OP_ARR  = 8'h6B;
  localparam logic [7:0] OP_SBX  = 8'hCB;
  localparam logic [7:0] OP_LXA  = 8'hAB;
  localparam logic [7:0] OP_ANE  = 8'h8B;
  localparam logic [7:0] OP_SHAY = 8'h9F;
  localparam logic [7:0] OP_SHAI = 8'h93;
  localparam logic [7:0] OP_SHS  = 8'h9B;

  // flag mask bit positions
  localparam int FB_N = 3;
  localparam int FB_V = 2;
  localparam int FB_Z = 1;
  localparam int FB_C = 0;

  typedef struct packed {
    logic [UX_W-1:0] a;
    logic            a_we;
    logic [UX_W-1:0] x;
    logic            x_we;
    logic [UX_W-1:0] s;
    logic            s_we;
    logic [UX_W-1:0] mem;
    logic            mem_we;
    logic [UX_W-1:0] ahi;
    logic            ahi_we;
    logic            n;
    logic            v;
    logic            z;
    logic            c;
    logic [3:0]      fwe;
  } ux_result_t;

  function automatic logic is_known(input logic [7:0] op);
    return (op == OP_ARR) || (op == OP_SBX) || (op == OP_LXA) || (op == OP_ANE) ||
           (op == OP_SHAY) || (op == OP_SHAI) || (op == OP_SHS);
  endfunction
endpackage

// File: rtl/ux_rotate.sv
module ux_rotate
  import undoc_pkg::*;
(
  input  logic [UX_W-1:0] a,
  input  logic [UX_W-1:0] oper,
  input  logic            c_in,
  output ux_result_t      res
);
  logic [UX_W-1:0] masked;
  logic [UX_W-1:0] rot;

  always_comb begin
    masked = a & oper;
    rot    = {c_in, masked[UX_W-1:1]};
    res        = '0;
    res.a      = rot;
    res.a_we   = 1'b1;
    res.n      = rot[UX_W-1];
    res.z      = (rot == '0);
    res.c      = rot[UX_W-2];
    res.v      = rot[UX_W-2] ^ rot[UX_W-3];
    res.fwe    = 4'b1111;
  end
endmodule

// File: rtl/ux_logic_ops.sv
module ux_logic_ops
  import undoc_pkg::*;
#(
  parameter logic [UX_W-1:0] MAGIC_K = 8'hEE
) (
  input  logic [7:0]      opcode,
  input  logic [UX_W-1:0] a,
  input  logic [UX_W-1:0] x,
  input  logic [UX_W-1:0] oper,
  output ux_result_t      res
);
  logic [UX_W-1:0] ax;
  logic [UX_W:0]   diff;
  logic [UX_W-1:0] base;
  logic [UX_W-1:0] val;

  always_comb begin
    ax   = a & x;
    diff = {1'b0, ax} - {1'b0, oper};
    base = a | MAGIC_K;
    res  = '0;
    val  = '0;
    unique case (opcode)
      OP_SBX: begin
        val      = diff[UX_W-1:0];
        res.x    = val;
        res.x_we = 1'b1;
        res.c    = ~diff[UX_W];
        res.fwe  = 4'b1011;
      end
      OP_LXA: begin
        val      = base & oper;
        res.a    = val;
        res.a_we = 1'b1;
        res.x    = val;
        res.x_we = 1'b1;
        res.fwe  = 4'b1010;
      end
      OP_ANE: begin
        val      = base & x & oper;
        res.a    = val;
        res.a_we = 1'b1;
        res.fwe  = 4'b1010;
      end
      default: ;
    endcase
    res.n = val[UX_W-1];
    res.z = (val == '0);
  end
endmodule

// File: rtl/ux_store.sv
module ux_store
  import undoc_pkg::*;
(
  input  logic [7:0]      opcode,
  input  logic [UX_W-1:0] a,
  input  logic [UX_W-1:0] x,
  input  logic [UX_W-1:0] addr_hi,
  input  logic            page_cross,
  output ux_result_t      res
);
  logic [UX_W-1:0] hi_inc;
  logic [UX_W-1:0] ax;
  logic [UX_W-1:0] data;

  always_comb begin
    hi_inc = addr_hi + 1'b1;   // wraps modulo 2^UX_W
    ax     = a & x;
    data   = ax & hi_inc;
    res    = '0;
    res.mem    = data;
    res.mem_we = 1'b1;
    if (opcode == OP_SHS) begin
      res.s    = ax;
      res.s_we = 1'b1;
    end
    if (page_cross) begin
      res.ahi    = data;
      res.ahi_we = 1'b1;
    end
  end
endmodule

// File: rtl/undoc_exec_unit.sv
module undoc_exec_unit
  import undoc_pkg::*;
#(
  parameter logic [7:0] MAGIC_K = 8'hEE
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_opcode,
  input  logic [7:0] in_a,
  input  logic [7:0] in_x,
  input  logic       in_c,
  input  logic [7:0] in_oper,
  input  logic [7:0] in_addr_hi,
  input  logic       in_page_cross,
  output logic [7:0] out_a,
  output logic       out_a_we,
  output logic [7:0] out_x,
  output logic       out_x_we,
  output logic [7:0] out_s,
  output logic       out_s_we,
  output logic [7:0] out_mem_data,
  output logic       out_mem_we,
  output logic [7:0] out_addr_hi,
  output logic       out_addr_hi_we,
  output logic       out_n,
  output logic       out_v,
  output logic       out_z,
  output logic       out_c,
  output logic [3:0] out_flag_we
);
  ux_result_t rot_res, log_res, st_res, nxt, q;

  ux_rotate u_rot (
    .a(in_a), .oper(in_oper), .c_in(in_c), .res(rot_res)
  );

  ux_logic_ops #(.MAGIC_K(MAGIC_K)) u_log (
    .opcode(in_opcode), .a(in_a), .x(in_x), .oper(in_oper), .res(log_res)
  );

  ux_store u_st (
    .opcode(in_opcode), .a(in_a), .x(in_x), .addr_hi(in_addr_hi),
    .page_cross(in_page_cross), .res(st_res)
  );

  always_comb begin
    unique case (in_opcode)
      OP_ARR:                  nxt = rot_res;
      OP_SBX, OP_LXA, OP_ANE:  nxt = log_res;
      OP_SHAY, OP_SHAI, OP_SHS: nxt = st_res;
      default:                 nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (in_valid) q <= nxt;
  end

  assign out_a          = q.a;
  assign out_a_we       = q.a_we;
  assign out_x          = q.x;
  assign out_x_we       = q.x_we;
  assign out_s          = q.s;
  assign out_s_we       = q.s_we;
  assign out_mem_data   = q.mem;
  assign out_mem_we     = q.mem_we;
  assign out_addr_hi    = q.ahi;
  assign out_addr_hi_we = q.ahi_we;
  assign out_n          = q.n;
  assign out_v          = q.v;
  assign out_z          = q.z;
  assign out_c          = q.c;
  assign out_flag_we    = q.fwe;

  assert_arr_carry_in_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_opcode == OP_ARR) |=> (out_a[7] == $past(in_c) && out_flag_we == 4'b1111));

  assert_sbx_compare_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_opcode == OP_SBX) |=>
      (out_x_we && !out_a_we && out_flag_we == 4'b1011 &&
       out_c == ($past(in_a & in_x) >= $past(in_oper))));

  assert_store_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    out_mem_we |-> (!out_a_we && !out_x_we && out_flag_we == 4'b0000));

  assert_override_match_R9: assert property (@(posedge clk) disable iff (rst)
    out_addr_hi_we |-> (out_mem_we && out_addr_hi == out_mem_data));

  assert_unknown_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !is_known(in_opcode)) |=>
      (!out_a_we && !out_x_we && !out_s_we && !out_mem_we && !out_addr_hi_we && out_flag_we == 4'b0000));

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_a) && $stable(out_x) && $stable(out_s) && $stable(out_mem_data) &&
                   $stable(out_flag_we) && $stable(out_mem_we)));
endmodule

// File: tb/undoc_exec_unit_tb.sv
`timescale 1ns/1ps
module undoc_exec_unit_tb;
  localparam logic [7:0] K = 8'hEE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_opcode = '0, in_a = '0, in_x = '0, in_oper = '0, in_addr_hi = '0;
  logic in_c = 1'b0, in_page_cross = 1'b0;
  logic [7:0] out_a, out_x, out_s, out_mem_data, out_addr_hi;
  logic out_a_we, out_x_we, out_s_we, out_mem_we, out_addr_hi_we;
  logic out_n, out_v, out_z, out_c;
  logic [3:0] out_flag_we;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  undoc_exec_unit #(.MAGIC_K(K)) u_dut (.*);

  // model state: {a,awe,x,xwe,s,swe,mem,mwe,ahi,hwe,n,v,z,c,fwe}
  logic [52:0] exp_q = '0;
  string exp_tag = "R1";

  function automatic logic [52:0] model(input logic [7:0] op, a, x, oper, hi,
                                        input logic cin, pc);
    int r, t, h;
    logic [7:0] A = 0, X = 0, S = 0, M = 0, H = 0;
    logic awe = 0, xwe = 0, swe = 0, mwe = 0, hwe = 0, n = 0, v = 0, z = 0, c = 0;
    logic [3:0] f = 0;
    h = (hi + 1) % 256;
    case (op)
      8'h6B: begin
        t = a & oper;
        r = (t / 2) + (cin ? 128 : 0);
        A = r; awe = 1; f = 4'b1111;
        n = r >= 128; z = r == 0; c = (r / 64) % 2;
        v = ((r / 64) % 2) != ((r / 32) % 2);
      end
      8'hCB: begin
        t = a & x;
        r = t - oper;
        c = r >= 0;
        X = (r + 256) % 256; xwe = 1; f = 4'b1011;
        n = X >= 128; z = X == 0;
      end
      8'hAB: begin
        A = (a | K) & oper; X = A; awe = 1; xwe = 1; f = 4'b1010;
        n = A >= 128; z = A == 0;
      end
      8'h8B: begin
        A = (a | K) & x & oper; awe = 1; f = 4'b1010;
        n = A >= 128; z = A == 0;
      end
      8'h9F, 8'h93, 8'h9B: begin
        M = a & x & h[7:0]; mwe = 1;
        if (op == 8'h9B) begin S = a & x; swe = 1; end
        if (pc) begin H = M; hwe = 1; end
      end
      default: ;
    endcase
    return {A, awe, X, xwe, S, swe, M, mwe, H, hwe, n, v, z, c, f};
  endfunction

  function automatic string tag_of(input logic [7:0] op, hi, input logic pc);
    case (op)
      8'h6B: return "R2";
      8'hCB: return "R3";
      8'hAB: return "R4";
      8'h8B: return "R5";
      8'h9F, 8'h93, 8'h9B: begin
        if (hi == 8'hFF) return "R8";
        if (pc) return "R9";
        return (op == 8'h9B) ? "R7" : "R6";
      end
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      exp_q <= '0; exp_tag <= "R1";
    end else if (in_valid) begin
      exp_q <= model(in_opcode, in_a, in_x, in_oper, in_addr_hi, in_c, in_page_cross);
      exp_tag <= tag_of(in_opcode, in_addr_hi, in_page_cross);
    end else begin
      exp_tag <= "R11";
    end
  end

  task automatic check_now();
    logic [52:0] act;
    act = {out_a, out_a_we, out_x, out_x_we, out_s, out_s_we, out_mem_data, out_mem_we,
           out_addr_hi, out_addr_hi_we, out_n, out_v, out_z, out_c, out_flag_we};
    n_checks++;
    if (act !== exp_q) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", exp_tag, act, exp_q);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] op, a, x, oper, hi,
                      input logic cin, pc);
    @(negedge clk);
    check_now();
    in_valid = v; in_opcode = op; in_a = a; in_x = x; in_oper = oper;
    in_addr_hi = hi; in_c = cin; in_page_cross = pc;
  endtask

  task automatic idle();
    step(1'b0, $urandom, $urandom, $urandom, $urandom, $urandom, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    in_valid = 1'b1; in_opcode = 8'h6B; in_a = 8'hFF; in_oper = 8'hFF; // ignored in reset (R1)
    @(negedge clk);
    check_now();
    rst = 1'b0; in_valid = 1'b0;
    // R2 rotate with carry in and out
    step(1, 8'h6B, 8'hFF, 8'h00, 8'hFF, 8'h00, 1, 0);
    step(1, 8'h6B, 8'h41, 8'h00, 8'hC1, 8'h00, 0, 0);
    step(1, 8'h6B, 8'h01, 8'h00, 8'h01, 8'h00, 0, 0);
    // R3 borrow edges
    step(1, 8'hCB, 8'hF0, 8'h3C, 8'h30, 8'h00, 0, 0);
    step(1, 8'hCB, 8'hF0, 8'h3C, 8'h31, 8'h00, 1, 0);
    step(1, 8'hCB, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0);
    // R4 / R5 with the magic constant
    step(1, 8'hAB, 8'h00, 8'h55, 8'hFF, 8'h00, 0, 0);
    step(1, 8'hAB, 8'h11, 8'h00, 8'h11, 8'h00, 0, 0);
    step(1, 8'h8B, 8'h01, 8'hF0, 8'hFF, 8'h00, 0, 0);
    step(1, 8'h8B, 8'h10, 8'h0F, 8'hFF, 8'h00, 0, 0);
    // R6 / R7 / R8 / R9 stores
    step(1, 8'h9F, 8'hFF, 8'h3F, 8'h00, 8'h12, 0, 0);
    step(1, 8'h93, 8'hFF, 8'hFF, 8'h00, 8'h7F, 0, 1);
    step(1, 8'h9B, 8'hF3, 8'h3F, 8'h00, 8'h04, 0, 0);
    step(1, 8'h9B, 8'hFF, 8'hFF, 8'h00, 8'hFF, 0, 1);
    step(1, 8'h9F, 8'hFF, 8'hFF, 8'h00, 8'hFF, 0, 0);
    // R10 unknown opcodes after a busy result
    step(1, 8'h6B, 8'hFF, 8'h00, 8'hFF, 8'h00, 1, 0);
    step(1, 8'hEA, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 1, 1);
    step(1, 8'h6A, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 1, 1);
    // R11 hold
    step(1, 8'hCB, 8'h0F, 8'hFF, 8'h01, 8'h00, 0, 0);
    repeat (4) idle();
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] ops [8] = '{8'h6B, 8'hCB, 8'hAB, 8'h8B, 8'h9F, 8'h93, 8'h9B, 8'h00};
      logic [7:0] op;
      op = ops[$urandom_range(0, 7)];
      if (op == 8'h00) op = $urandom;
      step($urandom_range(0, 3) != 0, op, $urandom, $urandom, $urandom, $urandom,
           $urandom_range(0, 1), $urandom_range(0, 1));
    end
    step(0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check_now();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 100000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule